// File: doc/BRIEF.md
# Next Program Counter Unit

This block sequences the program counter of a small two-stage microcontroller core whose program memory is addressed in 16-bit words. Each cycle the decoder hands it a 3-bit class code for the instruction in execute, plus the operand fields that could form a jump target. The unit picks one of five targets and loads it into a 22-bit PC register on the next enabled clock edge. The five targets are: step by one word, step by two words, a signed relative displacement, an absolute target split across two instruction words, and a pointer-register indirect target.

The combinational `nextPc` output is the value the register will load. Fetch can use it to start the next access early. `isLongInst` marks an instruction that occupies two program words, so fetch knows the word after the opcode is an operand and not an instruction. The return stack, interrupt vectoring and decoding are outside this block.

Top module: `next_pc_unit`

## Requirements
- R1: Class code 0 (plain one-word instruction) loads PC+1, wrapping modulo 2^22.
- R2: Class code 1 (two-word instruction that does not branch) loads PC+2, and `isLongInst` is 1 for that code.
- R3: Class code 2 (relative jump) loads PC+1+k. Here k is the 12-bit `relOffset` read as a two's-complement value from -2048 to +2047 and sign-extended to 22 bits, and the sum wraps modulo 2^22.
- R4: Class code 3 (conditional relative branch) loads PC+1+k when `branchTaken` is 1, and PC+1 when it is 0.
- R5: Class code 4 (absolute jump) loads `highBits` into PC[21:16] and `secondWord` into PC[15:0], and `isLongInst` is 1 for that code.
- R6: Class code 5 (indirect jump) loads `zPtr` zero-extended to 22 bits, so PC[21:16] becomes 0.
- R7: Class codes 6 and 7 are reserved. They behave as code 0 (PC+1), and `isLongInst` is 0 for them.
- R8: While `rst` is 1 at a rising edge, the PC becomes 0 whatever `en` is. Reset is synchronous.
- R9: While `en` is 0, `pcOut` keeps its value across the edge, and `nextPc` still shows the selected target.
- R10: `nextPc` is combinational from the current PC and the inputs, and equals the value `pcOut` takes after the next enabled edge. `isLongInst` is 0 for codes 0, 2, 3, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | PC update enable |
| instClass | input | 3 | Instruction class code (0..7) |
| relOffset | input | 12 | Signed relative displacement k |
| highBits | input | 6 | Upper target bits from the first instruction word |
| secondWord | input | 16 | Second instruction word, lower target bits |
| zPtr | input | 16 | Pointer register used for indirect jumps |
| branchTaken | input | 1 | Condition result for a conditional relative branch |
| nextPc | output | 22 | Combinational next PC value |
| pcOut | output | 22 | Registered current PC |
| isLongInst | output | 1 | Instruction occupies two program words |

## Verification
Clocked properties check on every cycle:
- that exactly one target source is selected;
- that each class moves the PC by the right amount or loads the right target on the following edge;
- that a disabled edge holds the PC;
- that a reset cycle leaves the PC at zero.

Only the bench scenarios can show the numeric corner cases. These are wrap-around at both ends of the 22-bit space from the extreme values of k, absolute targets above the 64K-word boundary, the zero fill of the indirect target, and the two-word step landing exactly past the operand word.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    CLS_SEQ  = 3'd0,
    CLS_LONG = 3'd1,
    CLS_REL  = 3'd2,
    CLS_CREL = 3'd3,
    CLS_ABS  = 3'd4,
    CLS_IND  = 3'd5,
    CLS_RSV6 = 3'd6,
    CLS_RSV7 = 3'd7
  } instClass_e;

  // one strobe per target source, plus the two-word marker
  typedef struct packed {
    logic selStep1;
    logic selStep2;
    logic selRel;
    logic selAbs;
    logic selInd;
    logic longWord;
  } npcStrobes_t;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  instClass,
  input  logic        branchTaken,
  output npcStrobes_t strobes
);

  instClass_e clsDec;

  always_comb begin
    clsDec  = instClass_e'(instClass);
    strobes = '0;
    case (clsDec)
      CLS_LONG: begin
        strobes.selStep2 = 1'b1;
        strobes.longWord = 1'b1;
      end
      CLS_REL:  strobes.selRel = 1'b1;
      CLS_CREL: begin
        if (branchTaken) strobes.selRel = 1'b1;
        else             strobes.selStep1 = 1'b1;
      end
      CLS_ABS: begin
        strobes.selAbs   = 1'b1;
        strobes.longWord = 1'b1;
      end
      CLS_IND:  strobes.selInd = 1'b1;
      default:  strobes.selStep1 = 1'b1;
    endcase
  end

  // R10: the datapath mux must see exactly one source
  p_one_source_r10: assert property (@(posedge clk) disable iff (rst)
    $countones({strobes.selStep1, strobes.selStep2, strobes.selRel,
                strobes.selAbs, strobes.selInd}) == 1);

  // R4: an untaken conditional branch falls through
  p_cond_fallthru_r4: assert property (@(posedge clk) disable iff (rst)
    (instClass == 3'd3 && !branchTaken) |-> strobes.selStep1);

  // R7: reserved codes act as plain one-word instructions
  p_reserved_r7: assert property (@(posedge clk) disable iff (rst)
    (instClass[2:1] == 2'b11) |-> (strobes.selStep1 && !strobes.longWord));

endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int PcW   = 22,
  parameter int OffW  = 12,
  parameter int WordW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  npcStrobes_t      strobes,
  input  logic [OffW-1:0]  relOffset,
  input  logic [PcW-WordW-1:0] highBits,
  input  logic [WordW-1:0] secondWord,
  input  logic [WordW-1:0] zPtr,
  output logic [PcW-1:0]   nextPc,
  output logic [PcW-1:0]   pcOut
);

  localparam int ExtW = PcW - OffW;
  localparam int ZpW  = PcW - WordW;

  logic [PcW-1:0] pcReg;
  logic [PcW-1:0] stepOne, stepTwo, relTgt, absTgt, indTgt, offExt;

  generate
    if (ExtW > 0) begin : g_sext
      assign offExt = {{ExtW{relOffset[OffW-1]}}, relOffset};
    end else begin : g_trunc
      assign offExt = relOffset[PcW-1:0];
    end
  endgenerate

  assign stepOne = pcReg + PcW'(1);
  assign stepTwo = pcReg + PcW'(2);
  assign relTgt  = stepOne + offExt;
  assign absTgt  = {highBits, secondWord};
  assign indTgt  = {{ZpW{1'b0}}, zPtr};

  always_comb begin
    nextPc = stepOne;
    if (strobes.selStep2)     nextPc = stepTwo;
    else if (strobes.selRel)  nextPc = relTgt;
    else if (strobes.selAbs)  nextPc = absTgt;
    else if (strobes.selInd)  nextPc = indTgt;
  end

  always_ff @(posedge clk) begin
    if (rst)     pcReg <= '0;
    else if (en) pcReg <= nextPc;
  end

  assign pcOut = pcReg;

  // R8: remember a reset edge to check the cleared PC afterwards
  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= rst;

  always_ff @(posedge clk) begin
    if (rstSeen && !rst) begin
      p_reset_clear_r8: assert (pcReg == '0);
    end
  end

  p_step_one_r1: assert property (@(posedge clk) disable iff (rst)
    (en && strobes.selStep1) |=> pcReg == $past(pcReg) + PcW'(1));

  p_step_two_r2: assert property (@(posedge clk) disable iff (rst)
    (en && strobes.selStep2) |=> pcReg == $past(pcReg) + PcW'(2));

  p_rel_target_r3: assert property (@(posedge clk) disable iff (rst)
    (en && strobes.selRel) |=>
      $signed(pcReg - $past(pcReg) - PcW'(1)) == $signed($past(offExt)));

  p_abs_target_r5: assert property (@(posedge clk) disable iff (rst)
    (en && strobes.selAbs) |=>
      (pcReg[WordW-1:0] == $past(secondWord) && pcReg[PcW-1:WordW] == $past(highBits)));

  p_ind_target_r6: assert property (@(posedge clk) disable iff (rst)
    (en && strobes.selInd) |=>
      (pcReg[WordW-1:0] == $past(zPtr) && pcReg[PcW-1:WordW] == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pcReg));

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int PcW   = 22,
  parameter int OffW  = 12,
  parameter int WordW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [2:0]           instClass,
  input  logic [OffW-1:0]      relOffset,
  input  logic [PcW-WordW-1:0] highBits,
  input  logic [WordW-1:0]     secondWord,
  input  logic [WordW-1:0]     zPtr,
  input  logic                 branchTaken,
  output logic [PcW-1:0]       nextPc,
  output logic [PcW-1:0]       pcOut,
  output logic                 isLongInst
);

  npcStrobes_t strobes;

  npc_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .instClass   (instClass),
    .branchTaken (branchTaken),
    .strobes     (strobes)
  );

  npc_datapath #(
    .PcW   (PcW),
    .OffW  (OffW),
    .WordW (WordW)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .strobes    (strobes),
    .relOffset  (relOffset),
    .highBits   (highBits),
    .secondWord (secondWord),
    .zPtr       (zPtr),
    .nextPc     (nextPc),
    .pcOut      (pcOut)
  );

  assign isLongInst = strobes.longWord;

endmodule

// File: tb/next_pc_unit_bench.sv
module next_pc_unit_bench;

  localparam int PcMod = 4194304;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [2:0]  instClass = 3'd0;
  logic [11:0] relOffset = '0;
  logic [5:0]  highBits = '0;
  logic [15:0] secondWord = '0;
  logic [15:0] zPtr = '0;
  logic        branchTaken = 1'b0;
  logic [21:0] nextPc, pcOut;
  logic        isLongInst;

  next_pc_unit u_next_pc_unit (
    .clk(clk), .rst(rst), .en(en), .instClass(instClass),
    .relOffset(relOffset), .highBits(highBits), .secondWord(secondWord),
    .zPtr(zPtr), .branchTaken(branchTaken), .nextPc(nextPc),
    .pcOut(pcOut), .isLongInst(isLongInst)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    pc;
    string req;
  } expItem_t;

  expItem_t scoreQ[$];
  int checks = 0;
  int failures = 0;
  int modelPc = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int wrapPc(input int v);
    return ((v % PcMod) + PcMod) % PcMod;
  endfunction

  function automatic int expNext(input int cls, input int k, input int hi,
                                 input int sw, input int z, input bit bt);
    case (cls)
      1: return wrapPc(modelPc + 2);
      2: return wrapPc(modelPc + 1 + k);
      3: return bt ? wrapPc(modelPc + 1 + k) : wrapPc(modelPc + 1);
      4: return hi * 65536 + sw;
      5: return z;
      default: return wrapPc(modelPc + 1);
    endcase
  endfunction

  // driver: applies one instruction, checks combinational outputs, queues result
  task automatic runOp(input int cls, input int k, input int hi, input int sw,
                       input int z, input bit bt, input bit enV, input string req);
    int nx;
    expItem_t it;
    @(negedge clk);
    rst = 1'b0; en = enV; instClass = cls[2:0]; relOffset = k[11:0];
    highBits = hi[5:0]; secondWord = sw[15:0]; zPtr = z[15:0]; branchTaken = bt;
    #1;
    nx = expNext(cls, k, hi, sw, z, bt);
    chk({req, " R10 nextPc"}, int'(nextPc), nx);
    chk({req, " isLongInst"}, int'(isLongInst), (cls == 1 || cls == 4) ? 1 : 0);
    if (enV) modelPc = nx;
    it.pc = modelPc; it.req = req;
    scoreQ.push_back(it);
  endtask

  task automatic doReset(input bit enV);
    expItem_t it;
    @(negedge clk);
    rst = 1'b1; en = enV; instClass = 3'd0;
    modelPc = 0;
    it.pc = 0; it.req = "R8 reset";
    scoreQ.push_back(it);
  endtask

  // monitor: compares the registered PC after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (scoreQ.size() != 0) begin
        expItem_t it;
        it = scoreQ.pop_front();
        chk({it.req, " pcOut"}, int'(pcOut), it.pc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    doReset(1'b1);
    doReset(1'b0);
    // R1 plain steps
    runOp(0, 0, 0, 0, 0, 0, 1, "R1");
    runOp(0, 0, 0, 0, 0, 0, 1, "R1");
    runOp(0, 0, 0, 0, 0, 0, 1, "R1");
    // R2 two-word step lands past the operand word
    runOp(1, 0, 0, 0, 0, 0, 1, "R2");
    runOp(0, 0, 0, 0, 0, 0, 1, "R1");
    runOp(1, 0, 0, 0, 0, 0, 1, "R2");
    // R3 forward and backward relative
    runOp(2, 100, 0, 0, 0, 0, 1, "R3 fwd");
    runOp(2, -5, 0, 0, 0, 0, 1, "R3 back");
    // R3 extremes with wrap below zero and back
    doReset(1'b0);
    runOp(2, -2048, 0, 0, 0, 0, 1, "R3 kmin wrap");
    runOp(2, 2047, 0, 0, 0, 0, 1, "R3 kmax wrap");
    runOp(2, 2047, 0, 0, 0, 0, 1, "R3 kmax");
    // R4 conditional branch
    runOp(3, 16, 0, 0, 0, 1, 1, "R4 taken");
    runOp(3, 16, 0, 0, 0, 0, 1, "R4 not taken");
    runOp(3, -300, 0, 0, 0, 1, 1, "R4 taken back");
    // R5 absolute above 64K words
    runOp(4, 0, 6'h3F, 16'hABCD, 0, 0, 1, "R5 high");
    runOp(1, 0, 0, 0, 0, 0, 1, "R2 high");
    runOp(4, 0, 6'h01, 16'h0000, 0, 0, 1, "R5 64K");
    runOp(4, 0, 6'h3F, 16'hFFFF, 0, 0, 1, "R5 top");
    runOp(0, 0, 0, 0, 0, 0, 1, "R1 wrap top");
    // R6 indirect from a high PC
    runOp(4, 0, 6'h2A, 16'h1234, 0, 0, 1, "R5");
    runOp(5, 0, 0, 0, 16'hFFFF, 0, 1, "R6 zero fill");
    runOp(5, 0, 0, 0, 16'h0040, 0, 1, "R6");
    // R7 reserved codes
    runOp(6, 77, 6'h3F, 16'h5555, 16'h7777, 1, 1, "R7 code6");
    runOp(7, 77, 6'h3F, 16'h5555, 16'h7777, 1, 1, "R7 code7");
    // R9 hold while disabled
    runOp(2, 500, 0, 0, 0, 0, 0, "R9 hold rel");
    runOp(4, 0, 6'h11, 16'h2222, 0, 0, 0, "R9 hold abs");
    runOp(0, 0, 0, 0, 0, 0, 1, "R9 resume");
    // R8 reset wins over enable mid-run
    runOp(4, 0, 6'h30, 16'h0F0F, 0, 0, 1, "R5");
    doReset(1'b1);
    runOp(0, 0, 0, 0, 0, 0, 1, "R8 after reset");
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule